// File: doc/BRIEF.md
# Bridge interrupt aggregation controller

This block gathers eleven level-sensitive device interrupt lines into one processor interrupt. The interrupt is sent as a posted write message, not as a wire. Software sets up a target register. Its upper bits give the address the message is written to. Its low five bits give the data word, which tells the processor which interrupt this is.

A line that goes from low to high latches a bit in a pending register. The message is sent only when a latched rising edge falls on a line that the mask register enables. Software reads the pending register to find out which lines fired, and that read clears it. There is a second read view that returns only the enabled pending bits and also clears everything. A separate level view shows the live state of the lines, so a driver can find a line that is still held high after it has been serviced.

Only ten of the eleven line positions are implemented in the pending register. Position 9 never latches. The message port is a simple valid/ready request. While a message waits for acceptance, further triggers merge into it.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the pending, mask and target registers read as zero and `msg_valid` is low.
- R2: A rising edge on an implemented line sets its pending bit on the next clock. A line that stays high after its pending bit is cleared does not set the bit again.
- R3: Pending bits 0 to 8 and bit 10 are implemented (mask 0x5FF). An edge on line 9 never sets a pending bit and never sends a message. The bit reads as zero.
- R4: A read at offset 0x00C returns the pending bits in bits 10:0. The same access clears them, so the next read returns zero.
- R5: A read at offset 0x01C returns the pending bits ANDed with the mask, and clears all pending bits, including the masked ones.
- R6: A read at offset 0x028 returns the live line levels in bits 10:0, whatever the pending state. The read leaves the pending bits unchanged.
- R7: A rising edge on an implemented line whose mask bit is set raises `msg_valid` on the next clock. The message address is the target register with bits 4:0 forced to zero. The message data is the target's bits 4:0, zero-extended.
- R8: With the mask at zero, no message is sent, but pending bits still latch.
- R9: Setting a mask bit while its line is already high does not by itself send a message.
- R10: If a rising edge and a clearing read of the pending register fall in the same cycle, the read returns the old bits and the new edge's bit stays pending.
- R11: The target register at 0x004 and the mask register at 0x018 read back what was written (all 32 bits and bits 10:0 respectively).
- R12: `msg_valid` stays high until `msg_ready` is seen. Triggers that arrive while a message is outstanding are merged into that single message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (triggers read side effects) |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd` |
| irq_lines | input | 11 | Device interrupt lines, synchronous to `clk` |
| msg_valid | output | 1 | Interrupt message request |
| msg_ready | input | 1 | Message accepted |
| msg_addr | output | 32 | Message target address |
| msg_data | output | 32 | Message data word |

## Verification
The bench puts a rising edge in the same cycle as a clearing read. A design that lets the clear win would silently drop that interrupt. It unmasks a line that is already high, which an enable-triggered design would answer with a spurious message. It also checks that a level read leaves the pending bits in place; a design that shares the clear between the views would lose them. With acceptance held off, several edges must merge into one message. A design that queues a message per edge, or drops `msg_valid` early, shows up as an extra or missing message in the scoreboard. Line 9 is driven to catch a design that latches the unimplemented position.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int LINES = 11,
  parameter logic [LINES-1:0] IMPL = 11'h5FF,
  parameter int DATA_BITS = 5,
  parameter int AW = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [AW-1:0]    reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [LINES-1:0] irq_lines,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [31:0]      msg_addr,
  output logic [31:0]      msg_data
);
  localparam logic [AW-1:0] OFF_TARGET = AW'(12'h004);
  localparam logic [AW-1:0] OFF_PEND   = AW'(12'h00C);
  localparam logic [AW-1:0] OFF_MASK   = AW'(12'h018);
  localparam logic [AW-1:0] OFF_PEEK   = AW'(12'h01C);
  localparam logic [AW-1:0] OFF_LEVEL  = AW'(12'h028);

  logic [31:0]      target_q;
  logic [LINES-1:0] mask_q, pend_q, prev_q;
  logic [LINES-1:0] rise;
  logic             clr, fire;

  assign rise = irq_lines & ~prev_q & IMPL;
  assign clr  = reg_rd && (reg_addr == OFF_PEND || reg_addr == OFF_PEEK);
  assign fire = |(rise & mask_q);

  assign msg_addr = {target_q[31:DATA_BITS], {DATA_BITS{1'b0}}};
  assign msg_data = 32'(target_q[DATA_BITS-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      target_q  <= '0;
      mask_q    <= '0;
      pend_q    <= '0;
      prev_q    <= '0;
      msg_valid <= 1'b0;
    end else begin
      prev_q    <= irq_lines;
      pend_q    <= (clr ? '0 : pend_q) | rise;
      msg_valid <= fire | (msg_valid & ~msg_ready);
      if (reg_wr) begin
        if (reg_addr == OFF_TARGET) target_q <= reg_wdata;
        if (reg_addr == OFF_MASK)   mask_q   <= reg_wdata[LINES-1:0];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFF_TARGET: reg_rdata = target_q;
      OFF_PEND:   reg_rdata = 32'(pend_q);
      OFF_MASK:   reg_rdata = 32'(mask_q);
      OFF_PEEK:   reg_rdata = 32'(pend_q & mask_q);
      OFF_LEVEL:  reg_rdata = 32'(irq_lines);
      default:    reg_rdata = '0;
    endcase
  end

  assert_pend_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == OFF_PEND && rise == '0) |=> pend_q == '0);
  assert_edge_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((pend_q & $past(rise)) == $past(rise)));
  assert_level_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == OFF_LEVEL && rise == '0) |=> $stable(pend_q));
  assert_fire_msg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> msg_valid);
  assert_mask_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0 && !msg_valid) |=> !msg_valid);
  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> msg_valid);
  assert_no_bit9_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == OFF_PEND) |-> reg_rdata[9] == 1'b0);
endmodule

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [10:0] irq_lines = '0;
  logic        msg_valid;
  logic        msg_ready = 1'b1;
  logic [31:0] msg_addr, msg_data;

  int checks = 0, errors = 0;
  logic [63:0] expq[$];
  logic [31:0] rv;

  irq_aggregator dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_lines(irq_lines), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: transfer happens at the edge following this sample point
  always @(negedge clk) begin
    #4;
    if (rst_n && msg_valid && msg_ready) begin
      if (expq.size() == 0) chk(1'b0, "R8/R9/R12 spurious message", {msg_addr, msg_data}, 64'h0);
      else begin
        logic [63:0] e;
        e = expq.pop_front();
        chk({msg_addr, msg_data} == e, "R7 message content", {msg_addr, msg_data}, e);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #4 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic lines(input logic [10:0] v);
    @(negedge clk); irq_lines = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  localparam logic [63:0] MSG = {32'hABCDE000, 32'h00000013};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    chk(msg_valid == 1'b0, "R1 msg_valid", msg_valid, 0);
    rd(12'h00C, rv); chk(rv == 0, "R1 pending", rv, 0);
    rd(12'h018, rv); chk(rv == 0, "R1 mask", rv, 0);
    rd(12'h004, rv); chk(rv == 0, "R1 target", rv, 0);
    // R11
    wr(12'h004, 32'hABCDE013);
    rd(12'h004, rv); chk(rv == 32'hABCDE013, "R11 target readback", rv, 32'hABCDE013);
    wr(12'h018, 32'h7FF);
    rd(12'h018, rv); chk(rv == 32'h7FF, "R11 mask readback", rv, 32'h7FF);
    // R7, R2, R4
    expq.push_back(MSG);
    lines(11'h001); idle(3);
    chk(expq.size() == 0, "R7 message sent", expq.size(), 0);
    rd(12'h00C, rv); chk(rv == 32'h001, "R2/R4 pending read", rv, 32'h001);
    rd(12'h00C, rv); chk(rv == 0, "R4 cleared by read", rv, 0);
    idle(2);
    rd(12'h00C, rv); chk(rv == 0, "R2 held level does not relatch", rv, 0);
    lines(11'h000); idle(2);
    // R3
    lines(11'h200); idle(3);
    rd(12'h00C, rv); chk(rv == 0, "R3 bit9 not latched", rv, 0);
    rd(12'h028, rv); chk(rv == 32'h200, "R6 level shows bit9", rv, 32'h200);
    lines(11'h000); idle(2);
    // R6
    expq.push_back(MSG);
    lines(11'h408); idle(3);
    rd(12'h028, rv); chk(rv == 32'h408, "R6 level read", rv, 32'h408);
    rd(12'h00C, rv); chk(rv == 32'h408, "R6 level read keeps pending", rv, 32'h408);
    lines(11'h000); idle(2);
    // R5
    wr(12'h018, 32'h001);
    expq.push_back(MSG);
    lines(11'h011); idle(3);
    rd(12'h01C, rv); chk(rv == 32'h001, "R5 masked view", rv, 32'h001);
    rd(12'h00C, rv); chk(rv == 0, "R5 clears all pending", rv, 0);
    lines(11'h000); idle(2);
    // R8
    wr(12'h018, 32'h000);
    lines(11'h004); idle(4);
    rd(12'h00C, rv); chk(rv == 32'h004, "R8 pending latches while masked", rv, 32'h004);
    chk(msg_valid == 0, "R8 no message", msg_valid, 0);
    lines(11'h000); idle(2);
    // R9
    lines(11'h020); idle(3);
    rd(12'h00C, rv); chk(rv == 32'h020, "R9 pending before unmask", rv, 32'h020);
    wr(12'h018, 32'h020); idle(4);
    chk(msg_valid == 0, "R9 no message on unmask", msg_valid, 0);
    rd(12'h00C, rv); chk(rv == 0, "R9 no new pending", rv, 0);
    lines(11'h000); idle(2);
    // R10
    wr(12'h018, 32'h7FF);
    expq.push_back(MSG);
    lines(11'h002); idle(3);
    expq.push_back(MSG);
    @(negedge clk); reg_rd = 1'b1; reg_addr = 12'h00C; irq_lines = 11'h042;
    #4 rv = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
    chk(rv == 32'h002, "R10 read returns old bits", rv, 32'h002);
    rd(12'h00C, rv); chk(rv == 32'h040, "R10 edge survives clear", rv, 32'h040);
    lines(11'h000); idle(3);
    // R12
    msg_ready = 1'b0;
    expq.push_back(MSG);
    lines(11'h080); idle(2);
    lines(11'h180); idle(3);
    chk(msg_valid == 1, "R12 held while not ready", msg_valid, 1);
    msg_ready = 1'b1; idle(3);
    chk(msg_valid == 0, "R12 single merged message", msg_valid, 0);
    chk(expq.size() == 0, "R12 queue drained", expq.size(), 0);
    rd(12'h00C, rv); chk(rv == 32'h180, "R12 pending bits", rv, 32'h180);
    lines(11'h000); idle(3);
    chk(expq.size() == 0, "R7 all expected messages seen", expq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule